// File: doc/BRIEF.md
# Pipeline Hazard Stall and Squash Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline may advance. It compares the two source register indices of the instruction sitting in decode against the destination indices of the two older instructions still in execute and memory. On any live match it freezes the program counter and the fetch/decode register and injects an empty slot into execute. It also reacts to a taken jump or branch reported by execute. In that case it discards the two younger instructions and steers fetch to the target.

For end-to-end testing, the block contains the program counter and three pipeline slots: fetch/decode, decode/execute and execute/memory. Each slot carries an instruction tag and its write and memory enables. There is no result forwarding, so every read-after-write dependency on an in-flight instruction costs stall cycles. The bench supplies the fetched instruction's fields for the current program counter and the execute-stage jump decision.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` becomes 0x1000 and every slot becomes empty: `*_valid`=0, tag 0, all enables 0. The control outputs are 0 while `ex_jump` is 0.
- R2: With no hazard and no jump, `pc` rises by 4 per cycle, and an instruction fetched in cycle k appears in decode at k+1, in execute at k+2 and in memory at k+3.
- R3: A hazard exists when a decode source index equals the destination of the execute or memory slot and that slot's `rd_we` is 1. While a hazard exists and `ex_jump` is 0, `stall_pc`, `stall_ifid` and `flush_idex` are 1 in that same cycle.
- R4: After a stalled cycle, `pc` and the decode slot keep their values and the execute slot is empty.
- R5: A dependency on the instruction directly ahead costs two bubbles. A dependency on the instruction two ahead costs one bubble. The held instruction then enters execute.
- R6: Source index 0 never causes a hazard, even against a destination of 0 with `rd_we`=1. An older slot whose `rd_we` is 0 never causes a hazard.
- R7: When `ex_jump` is 1, `flush_ifid` and `flush_idex` are 1. On the next cycle `pc` equals `ex_target`, and the decode and execute slots are empty.
- R8: When a jump and a hazard coincide, `stall_pc` and `stall_ifid` are 0 and `pc` loads `ex_target`.
- R9: An empty slot has `valid`, `rd_we`, `mem_we` and `mem_re` all 0.
- R10: The execute slot always moves into the memory slot, including the jumping instruction itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_rs1 | input | 5 | First source index of fetched instruction |
| if_rs2 | input | 5 | Second source index of fetched instruction |
| if_rd | input | 5 | Destination index of fetched instruction |
| if_rd_we | input | 1 | Fetched instruction writes a register |
| if_mem_we | input | 1 | Fetched instruction writes memory |
| if_mem_re | input | 1 | Fetched instruction reads memory |
| if_tag | input | 8 | Identifier of fetched instruction |
| ex_jump | input | 1 | Execute resolved a taken jump or branch |
| ex_target | input | 32 | Jump destination address |
| pc | output | 32 | Current fetch address |
| stall_pc | output | 1 | Program counter holds |
| stall_ifid | output | 1 | Fetch/decode slot holds |
| flush_ifid | output | 1 | Fetch/decode slot cleared |
| flush_idex | output | 1 | Decode/execute slot cleared |
| id_valid | output | 1 | Decode slot holds an instruction |
| id_tag | output | 8 | Tag in decode |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_rd | output | 5 | Destination in execute |
| ex_rd_we | output | 1 | Register write enable in execute |
| ex_mem_we | output | 1 | Memory write enable in execute |
| ex_mem_re | output | 1 | Memory read enable in execute |
| ex_tag | output | 8 | Tag in execute |
| mem_valid | output | 1 | Memory slot holds an instruction |
| mem_rd | output | 5 | Destination in memory stage |
| mem_rd_we | output | 1 | Register write enable in memory stage |
| mem_mem_we | output | 1 | Memory write enable in memory stage |
| mem_mem_re | output | 1 | Memory read enable in memory stage |
| mem_tag | output | 8 | Tag in memory stage |

## Verification
The stall and flush outputs depend only on the registered slots and `ex_jump`, so they are due in the same cycle as the condition. The bench samples them a few nanoseconds after the new jump input has settled, before the next edge. Program counter and slot contents are due one edge after the decision. The bench therefore compares them in the following cycle against a per-cycle table of expected tags. In that table, the instruction that depends on the one directly ahead sits in decode for three cycles with two empty execute slots behind it. The jump cases check the flush outputs before the edge, and the target and empty slots after it.

// File: rtl/hz_pkg.sv
// Shared widths and slot formats for the hazard controller.
// Assumes a 32-entry register file and an 8-bit instruction tag.
package hz_pkg;
    parameter int REG_W = 5;
    parameter int TAG_W = 8;

    // Fields that travel past decode.
    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] rd;
        logic             rd_we;
        logic             mem_we;
        logic             mem_re;
        logic [TAG_W-1:0] tag;
    } exe_slot_t;

    // Decode slot: sources are consumed here and dropped afterwards.
    typedef struct packed {
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        exe_slot_t        body;
    } dec_slot_t;
endpackage

// File: rtl/hz_detect.sv
// Read-after-write comparator: every decode source against every older
// destination. Assumes index 0 is a constant-zero register.
module hz_detect #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2,
    parameter int N_OLD = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  logic [N_OLD-1:0][REG_W-1:0] dst,
    input  logic [N_OLD-1:0]            dst_we,
    output logic                        hazard
);
    localparam int N_PAIR = N_SRC * N_OLD;

    logic [N_PAIR-1:0] hit;

    // One comparator per source/older-stage pair.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        for (genvar o = 0; o < N_OLD; o++) begin : g_old
            assign hit[s*N_OLD+o] = dst_we[o] && (src[s] != '0) && (src[s] == dst[o]);
        end
    end

    // Any live match is a hazard.
    assign hazard = |hit;
endmodule

// File: rtl/hz_stage_reg.sv
// Generic pipeline slot with hold and clear. Clear wins over hold.
// Assumes the all-zero value of T is an empty slot.
module hz_stage_reg #(
    parameter type T = logic [7:0]
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic flush,
    input  T     d,
    output T     q
);
    // Slot update: reset or clear empties, hold keeps, else load.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (flush)  q <= '0;
        else if (!stall) q <= d;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> $stable(q)); // R4
    AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0)); // R9
endmodule

// File: rtl/hz_pc_reg.sv
// Fetch address register: jump target first, then hold, else step.
// Assumes fixed-size instructions of STEP bytes.
module hz_pc_reg #(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter int          STEP     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            jump,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);
    localparam logic [XLEN-1:0] BOOT_V = XLEN'(RESET_PC);

    // Next fetch address selection.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= BOOT_V;
        else if (jump)   pc <= target;
        else if (!stall) pc <= pc + STEP_V;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !jump) |=> (pc == $past(pc) + STEP_V)); // R2
    AST_PC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !jump) |=> $stable(pc)); // R4
    AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (pc == $past(target))); // R7
endmodule

// File: rtl/hz_pipe_ctrl.sv
// Hazard stall/squash controller with its program counter and three
// pipeline slots. Dependencies stall decode; a taken jump from execute
// clears decode and execute. Assumes no forwarding and register writes
// complete before a read issued after the memory stage.
module hz_pipe_ctrl
    import hz_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] if_rs1,
    input  logic [REG_W-1:0] if_rs2,
    input  logic [REG_W-1:0] if_rd,
    input  logic             if_rd_we,
    input  logic             if_mem_we,
    input  logic             if_mem_re,
    input  logic [TAG_W-1:0] if_tag,
    input  logic             ex_jump,
    input  logic [XLEN-1:0]  ex_target,
    output logic [XLEN-1:0]  pc,
    output logic             stall_pc,
    output logic             stall_ifid,
    output logic             flush_ifid,
    output logic             flush_idex,
    output logic             id_valid,
    output logic [TAG_W-1:0] id_tag,
    output logic             ex_valid,
    output logic [REG_W-1:0] ex_rd,
    output logic             ex_rd_we,
    output logic             ex_mem_we,
    output logic             ex_mem_re,
    output logic [TAG_W-1:0] ex_tag,
    output logic             mem_valid,
    output logic [REG_W-1:0] mem_rd,
    output logic             mem_rd_we,
    output logic             mem_mem_we,
    output logic             mem_mem_re,
    output logic [TAG_W-1:0] mem_tag
);
    localparam int N_SRC = 2;
    localparam int N_OLD = 2;

    dec_slot_t id_d, id_q;
    exe_slot_t ex_q, mem_q;
    logic      hazard;
    logic [N_SRC-1:0][REG_W-1:0] src_idx;
    logic [N_OLD-1:0][REG_W-1:0] dst_idx;
    logic [N_OLD-1:0]            dst_we;

    // Package the fetched instruction into a decode slot.
    always_comb begin
        id_d             = '0;
        id_d.rs1         = if_rs1;
        id_d.rs2         = if_rs2;
        id_d.body.valid  = 1'b1;
        id_d.body.rd     = if_rd;
        id_d.body.rd_we  = if_rd_we;
        id_d.body.mem_we = if_mem_we;
        id_d.body.mem_re = if_mem_re;
        id_d.body.tag    = if_tag;
    end

    // Gather comparator operands from decode, execute and memory.
    assign src_idx = {id_q.rs2, id_q.rs1};
    assign dst_idx = {mem_q.rd, ex_q.rd};
    assign dst_we  = {mem_q.rd_we, ex_q.rd_we};

    hz_detect #(.REG_W(REG_W), .N_SRC(N_SRC), .N_OLD(N_OLD)) u_detect (
        .src    (src_idx),
        .dst    (dst_idx),
        .dst_we (dst_we),
        .hazard (hazard)
    );

    // Control policy: a jump overrides a dependency stall.
    always_comb begin
        stall_pc   = hazard && !ex_jump;
        stall_ifid = hazard && !ex_jump;
        flush_ifid = ex_jump;
        flush_idex = ex_jump || hazard;
    end

    hz_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(4)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall_pc),
        .jump   (ex_jump),
        .target (ex_target),
        .pc     (pc)
    );

    hz_stage_reg #(.T(dec_slot_t)) u_ifid (
        .clk (clk), .rst_n (rst_n), .stall (stall_ifid), .flush (flush_ifid),
        .d   (id_d), .q (id_q)
    );

    hz_stage_reg #(.T(exe_slot_t)) u_idex (
        .clk (clk), .rst_n (rst_n), .stall (1'b0), .flush (flush_idex),
        .d   (id_q.body), .q (ex_q)
    );

    hz_stage_reg #(.T(exe_slot_t)) u_exmem (
        .clk (clk), .rst_n (rst_n), .stall (1'b0), .flush (1'b0),
        .d   (ex_q), .q (mem_q)
    );

    // Expose slot contents.
    assign id_valid   = id_q.body.valid;
    assign id_tag     = id_q.body.tag;
    assign ex_valid   = ex_q.valid;
    assign ex_rd      = ex_q.rd;
    assign ex_rd_we   = ex_q.rd_we;
    assign ex_mem_we  = ex_q.mem_we;
    assign ex_mem_re  = ex_q.mem_re;
    assign ex_tag     = ex_q.tag;
    assign mem_valid  = mem_q.valid;
    assign mem_rd     = mem_q.rd;
    assign mem_rd_we  = mem_q.rd_we;
    assign mem_mem_we = mem_q.mem_we;
    assign mem_mem_re = mem_q.mem_re;
    assign mem_tag    = mem_q.tag;

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_ifid |-> (stall_pc && flush_idex)); // R3
    AST_JUMP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ex_jump |-> (!stall_pc && !stall_ifid && flush_ifid && flush_idex)); // R8
    AST_JUMP_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        ex_jump |=> (!id_valid && !ex_valid)); // R7
    AST_ZERO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (id_q.rs1 == '0 && id_q.rs2 == '0) |-> !stall_pc); // R6
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (!ex_rd_we && !ex_mem_we && !ex_mem_re)); // R9
    AST_EX_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_tag == $past(ex_tag) && mem_valid == $past(ex_valid))); // R10
endmodule

// File: tb/hz_pipe_ctrl_tb.sv
`timescale 1ns/1ps
module hz_pipe_ctrl_tb;
    localparam int          XLEN = 32;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int          NROW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] if_rs1, if_rs2, if_rd;
    logic if_rd_we, if_mem_we, if_mem_re;
    logic [7:0] if_tag;
    logic ex_jump = 1'b0;
    logic [31:0] ex_target = '0;
    logic [31:0] pc;
    logic stall_pc, stall_ifid, flush_ifid, flush_idex;
    logic id_valid, ex_valid, mem_valid;
    logic [7:0] id_tag, ex_tag, mem_tag;
    logic [4:0] ex_rd, mem_rd;
    logic ex_rd_we, ex_mem_we, ex_mem_re, mem_rd_we, mem_mem_we, mem_mem_re;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    hz_pipe_ctrl #(.XLEN(XLEN), .RESET_PC(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd), .if_rd_we(if_rd_we),
        .if_mem_we(if_mem_we), .if_mem_re(if_mem_re), .if_tag(if_tag),
        .ex_jump(ex_jump), .ex_target(ex_target),
        .pc(pc), .stall_pc(stall_pc), .stall_ifid(stall_ifid),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex),
        .id_valid(id_valid), .id_tag(id_tag),
        .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_rd_we(ex_rd_we),
        .ex_mem_we(ex_mem_we), .ex_mem_re(ex_mem_re), .ex_tag(ex_tag),
        .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_rd_we(mem_rd_we),
        .mem_mem_we(mem_mem_we), .mem_mem_re(mem_mem_re), .mem_tag(mem_tag)
    );

    // Instruction image: {rs1, rs2, rd, rd_we, mem_we, mem_re, tag}.
    function automatic logic [25:0] prog(input logic [31:0] idx);
        logic [7:0] t;
        t = 8'(idx + 1);
        case (idx)
            0: return {5'd0, 5'd0, 5'd1, 3'b100, t};
            1: return {5'd3, 5'd4, 5'd2, 3'b100, t};
            2: return {5'd1, 5'd0, 5'd3, 3'b100, t};
            3: return {5'd0, 5'd3, 5'd4, 3'b100, t};
            4: return {5'd0, 5'd0, 5'd0, 3'b100, t};
            5: return {5'd0, 5'd0, 5'd6, 3'b100, t};
            6: return {5'd2, 5'd1, 5'd7, 3'b010, t};
            7: return {5'd7, 5'd0, 5'd8, 3'b101, t};
            default: return {5'd0, 5'd0, 5'd0, 3'b000, t};
        endcase
    endfunction

    // Fetch model: present the instruction at the current address.
    always_comb begin
        {if_rs1, if_rs2, if_rd, if_rd_we, if_mem_we, if_mem_re, if_tag} =
            prog((pc - BASE) >> 2);
    end

    // Per-cycle expectations: {pc[15:0], hazard, id tag, ex tag, mem tag}.
    localparam logic [40:0] EXP [NROW] = '{
        {16'h1000, 1'b0, 8'd0, 8'd0, 8'd0},
        {16'h1004, 1'b0, 8'd1, 8'd0, 8'd0},
        {16'h1008, 1'b0, 8'd2, 8'd1, 8'd0},
        {16'h100C, 1'b1, 8'd3, 8'd2, 8'd1},
        {16'h100C, 1'b0, 8'd3, 8'd0, 8'd2},
        {16'h1010, 1'b1, 8'd4, 8'd3, 8'd0},
        {16'h1010, 1'b1, 8'd4, 8'd0, 8'd3},
        {16'h1010, 1'b0, 8'd4, 8'd0, 8'd0},
        {16'h1014, 1'b0, 8'd5, 8'd4, 8'd0},
        {16'h1018, 1'b0, 8'd6, 8'd5, 8'd4},
        {16'h101C, 1'b0, 8'd7, 8'd6, 8'd5},
        {16'h1020, 1'b0, 8'd8, 8'd7, 8'd6},
        {16'h1024, 1'b0, 8'd9, 8'd8, 8'd7}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one edge and land mid-cycle.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        ex_jump = 1'b0;
        @(posedge clk); #2; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1;
        #3;
    endtask

    task automatic chk_empty(input string req);
        chk(req, "id_valid", 32'(id_valid), 0);
        chk(req, "ex_valid", 32'(ex_valid), 0);
        chk(req, "ex_enables", {29'd0, ex_rd_we, ex_mem_we, ex_mem_re}, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: state right after reset
        chk("R1", "pc", pc, BASE);
        chk("R1", "mem_valid", 32'(mem_valid), 0);
        chk("R1", "mem_enables", {29'd0, mem_rd_we, mem_mem_we, mem_mem_re}, 0);
        chk("R1", "controls", {28'd0, stall_pc, stall_ifid, flush_ifid, flush_idex}, 0);
        chk_empty("R9");

        // Table walk: R2 flow, R3/R5 stall windows, R6 x0 and write-disabled.
        for (int k = 0; k < NROW; k++) begin
            logic [40:0] r;
            r = EXP[k];
            chk("R2", $sformatf("pc row %0d", k), pc, {16'h0, r[40:25]});
            chk("R3", $sformatf("stall_pc row %0d", k), 32'(stall_pc), 32'(r[24]));
            chk("R3", $sformatf("stall_ifid row %0d", k), 32'(stall_ifid), 32'(r[24]));
            chk("R3", $sformatf("flush_idex row %0d", k), 32'(flush_idex), 32'(r[24]));
            chk("R5", $sformatf("id_tag row %0d", k), 32'(id_tag), 32'(r[23:16]));
            chk("R5", $sformatf("ex_tag row %0d", k), 32'(ex_tag), 32'(r[15:8]));
            chk("R10", $sformatf("mem_tag row %0d", k), 32'(mem_tag), 32'(r[7:0]));
            chk("R4", $sformatf("ex_valid row %0d", k), 32'(ex_valid), 32'(r[15:8] != 0));
            if (r[15:8] == 0) chk("R9", $sformatf("ex_rd_we row %0d", k), 32'(ex_rd_we), 0);
            if (k == 9 || k == 11) chk("R6", $sformatf("no stall row %0d", k), 32'(stall_pc), 0);
            step();
        end

        // R7: jump while first instruction is in execute.
        do_reset();
        step(); step();
        ex_jump = 1'b1; ex_target = 32'h0000_2000;
        #1;
        chk("R7", "flush_ifid", 32'(flush_ifid), 1);
        chk("R7", "flush_idex", 32'(flush_idex), 1);
        chk("R7", "stall_pc", 32'(stall_pc), 0);
        step();
        ex_jump = 1'b0;
        #1;
        chk("R7", "pc target", pc, 32'h0000_2000);
        chk_empty("R7");
        chk("R10", "jumper reaches mem", 32'(mem_tag), 1);
        step();
        chk("R7", "pc after target", pc, 32'h0000_2004);
        chk("R7", "target fetched", {31'd0, id_valid}, 1);

        // R8: jump arriving during a dependency stall.
        do_reset();
        step(); step(); step();
        chk("R8", "hazard present", 32'(flush_idex), 1);
        ex_jump = 1'b1; ex_target = 32'h0000_3000;
        #1;
        chk("R8", "stall_pc", 32'(stall_pc), 0);
        chk("R8", "stall_ifid", 32'(stall_ifid), 0);
        chk("R8", "flush_ifid", 32'(flush_ifid), 1);
        step();
        ex_jump = 1'b0;
        #1;
        chk("R8", "pc target", pc, 32'h0000_3000);
        chk_empty("R8");
        chk("R10", "mem after jump", 32'(mem_tag), 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule